// File: doc/BRIEF.md
# Stale-Acknowledge Guard for a Fast CPU on a Slow Bus

This block sits between a fast CPU and a slower legacy motherboard bus, and it shapes the active-low transfer acknowledge that goes back to the CPU. A legacy peripheral may keep its acknowledge low past the end of a bus cycle. If that happens, a fast CPU can start its next cycle while the old acknowledge is still low and end the new cycle too early. The guard treats any acknowledge that is already low when a cycle starts as left over from the previous cycle. It passes an acknowledge to the CPU only after it has seen the legacy line go high and then fall again within the current cycle.

Each cycle is sorted into one of three classes by its address when the CPU address strobe falls: ROM, RAM or I/O. Each class has its own extra rule:

- **ROM:** the strobe toward the legacy chipset is held inactive, which isolates the chipset from the access.
- **RAM:** the acknowledge is delayed by a fixed number of fast-clock cycles, because legacy data becomes valid a little after its acknowledge.
- **I/O:** an acknowledge opens a hold-off window that lasts for a number of rising edges of the slow reference clock. No acknowledge reaches the CPU while the window is open.

Top module: `ack_guard`

## Requirements
- R1: An acknowledge that is already low when the CPU strobe falls is ignored. `cpu_ack_n` stays high until the synchronized `legacy_ack_n` has been seen high at least once during the current cycle.
- R2: After that high has been seen, `legacy_ack_n` falling drives `cpu_ack_n` low 3 fast-clock edges later, for ROM and I/O cycles (two synchronizer stages plus one register).
- R3: During a ROM cycle, `legacy_as_n` stays high while `cpu_as_n` is low. ROM is the address range ROM_LO..ROM_HI, which is 0xE00000..0xEFFFFF by default. ROM takes priority over the other classes.
- R4: During RAM and I/O cycles, `legacy_as_n` follows `cpu_as_n`. RAM is RAM_LO..RAM_HI, which is 0x000000..0x3FFFFF by default. Any other address is I/O.
- R5: After an I/O cycle is acknowledged, no acknowledge reaches the CPU until HOLD_EDGES (default 3) synchronized rising edges of `ref_clk` have passed.
- R6: In a RAM cycle, `cpu_ack_n` falls RAM_DELAY (default 2) fast-clock edges later than R2 gives.
- R7: `cpu_ack_n` returns high in the same cycle that `cpu_as_n` goes high, with no clock edge in between.
- R8: The class is latched when the strobe falls. Changing `cpu_addr` later in the cycle changes neither the `legacy_as_n` gating nor the acknowledge timing.
- R9: During reset with `cpu_as_n` high, both `cpu_ack_n` and `legacy_as_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast CPU clock |
| rst_n | input | 1 | Active-low reset |
| cpu_as_n | input | 1 | CPU address strobe, active low |
| cpu_addr | input | ADDR_W | CPU address bus |
| ref_clk | input | 1 | Slow legacy reference clock |
| legacy_ack_n | input | 1 | Raw legacy transfer acknowledge, active low |
| cpu_ack_n | output | 1 | Guarded acknowledge to the CPU, active low |
| legacy_as_n | output | 1 | Address strobe toward the legacy chipset |

## Verification
All inputs are driven on the falling clock edge, and outputs are sampled on the falling edge just before the next input change. Each latency can therefore be counted in whole rising edges.

| Cycle type | Expected `cpu_ack_n` timing after `legacy_ack_n` falls | How the checks confirm it |
|---|---|---|
| ROM and I/O | Low after exactly 3 edges | Sampled high after 2 edges and low after 3 |
| RAM | Low after 3 + RAM_DELAY edges | Sampled at one edge short of that and at that edge |

The release of `cpu_ack_n` is checked one time step after `cpu_as_n` rises, with no clock edge in between. The I/O hold-off depends on the phase of the reference clock, so its check measures the gap between two acknowledges. That gap must fall between the minimum and the maximum span of three reference periods plus the synchronizer delay.

// File: rtl/ack_guard_pkg.sv
package ack_guard_pkg;

  typedef enum logic [1:0] {
    RGN_RAM = 2'd0,
    RGN_ROM = 2'd1,
    RGN_IO  = 2'd2
  } region_e;

  // ROM wins over RAM; anything else is I/O.
  function automatic region_e classify(input logic [31:0] a,
                                       input logic [31:0] rom_lo,
                                       input logic [31:0] rom_hi,
                                       input logic [31:0] ram_lo,
                                       input logic [31:0] ram_hi);
    if (a >= rom_lo && a <= rom_hi) return RGN_ROM;
    if (a >= ram_lo && a <= ram_hi) return RGN_RAM;
    return RGN_IO;
  endfunction

  // The acknowledge is fresh once a high was seen earlier in this cycle and
  // the line is low now.
  function automatic logic fresh_ack(input logic strobe_low,
                                     input logic starting,
                                     input logic high_seen,
                                     input logic ack_n_now);
    return strobe_low && !starting && high_seen && !ack_n_now;
  endfunction

endpackage

// File: rtl/ag_sync.sv
module ag_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/ag_region.sv
module ag_region
  import ack_guard_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] ROM_LO = 24'hE00000,
  parameter logic [ADDR_W-1:0] ROM_HI = 24'hEFFFFF,
  parameter logic [ADDR_W-1:0] RAM_LO = 24'h000000,
  parameter logic [ADDR_W-1:0] RAM_HI = 24'h3FFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycle_start,
  input  logic [ADDR_W-1:0] addr,
  output region_e           region_q,
  output logic              rom_now
);
  region_e region_live;

  assign region_live = classify(32'(addr), 32'(ROM_LO), 32'(ROM_HI),
                                32'(RAM_LO), 32'(RAM_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           region_q <= RGN_RAM;
    else if (cycle_start) region_q <= region_live;
  end

  // In the first cycle the latch is not yet loaded, so decode live.
  assign rom_now = cycle_start ? (region_live == RGN_ROM) : (region_q == RGN_ROM);
endmodule

// File: rtl/ag_qualify.sv
module ag_qualify
  import ack_guard_pkg::*;
#(
  parameter int RAM_DELAY  = 2,
  parameter int HOLD_EDGES = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cpu_as_n,
  input  logic    cycle_start,
  input  logic    leg_ack_n_s,
  input  logic    ref_rise,
  input  region_e region_q,
  output logic    grant_q,
  output logic    seen_high,
  output logic    hold_busy,
  output logic    delay_met
);
  localparam int HW = $clog2(HOLD_EDGES + 1);

  logic          ack_fresh;
  logic          grant_d;
  logic [HW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           seen_high <= 1'b0;
    else if (cycle_start) seen_high <= leg_ack_n_s;
    else if (!cpu_as_n)   seen_high <= seen_high | leg_ack_n_s;
  end

  assign ack_fresh = fresh_ack(!cpu_as_n, cycle_start, seen_high, leg_ack_n_s);

  generate
    if (RAM_DELAY == 0) begin : g_no_delay
      assign delay_met = 1'b1;
    end else begin : g_delay
      localparam int RW = $clog2(RAM_DELAY + 1);
      logic [RW-1:0] ram_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            ram_cnt <= '0;
        else if (cycle_start)  ram_cnt <= '0;
        else if (ack_fresh && region_q == RGN_RAM && ram_cnt != RW'(RAM_DELAY))
          ram_cnt <= ram_cnt + 1'b1;
      end
      assign delay_met = (region_q != RGN_RAM) || (ram_cnt == RW'(RAM_DELAY));
    end
  endgenerate

  assign hold_busy = (hold_cnt != '0);
  assign grant_d   = ack_fresh && delay_met && !hold_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        grant_q <= 1'b0;
    else if (cpu_as_n) grant_q <= 1'b0;
    else if (grant_d)  grant_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_cnt <= '0;
    else if (grant_d && !grant_q && region_q == RGN_IO)
      hold_cnt <= HW'(HOLD_EDGES);
    else if (ref_rise && hold_busy)
      hold_cnt <= hold_cnt - 1'b1;
  end
endmodule

// File: rtl/ack_guard.sv
module ack_guard
  import ack_guard_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int RAM_DELAY  = 2,
  parameter int HOLD_EDGES = 3,
  parameter logic [ADDR_W-1:0] ROM_LO = 24'hE00000,
  parameter logic [ADDR_W-1:0] ROM_HI = 24'hEFFFFF,
  parameter logic [ADDR_W-1:0] RAM_LO = 24'h000000,
  parameter logic [ADDR_W-1:0] RAM_HI = 24'h3FFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_as_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              ref_clk,
  input  logic              legacy_ack_n,
  output logic              cpu_ack_n,
  output logic              legacy_as_n
);
  logic    leg_ack_n_s, ref_s, ref_prev, ref_rise;
  logic    as_q, cycle_start;
  region_e region_q;
  logic    rom_now;
  logic    grant_q, seen_high, hold_busy, delay_met;

  ag_sync #(.W(2), .STAGES(2), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({legacy_ack_n, ref_clk}),
    .q({leg_ack_n_s, ref_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_prev <= 1'b0;
      as_q     <= 1'b1;
    end else begin
      ref_prev <= ref_s;
      as_q     <= cpu_as_n;
    end
  end

  assign ref_rise    = ref_s & ~ref_prev;
  assign cycle_start = as_q & ~cpu_as_n;

  ag_region #(
    .ADDR_W(ADDR_W), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI),
    .RAM_LO(RAM_LO), .RAM_HI(RAM_HI)
  ) u_region (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
    .addr(cpu_addr), .region_q(region_q), .rom_now(rom_now)
  );

  ag_qualify #(.RAM_DELAY(RAM_DELAY), .HOLD_EDGES(HOLD_EDGES)) u_qual (
    .clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n),
    .cycle_start(cycle_start), .leg_ack_n_s(leg_ack_n_s),
    .ref_rise(ref_rise), .region_q(region_q),
    .grant_q(grant_q), .seen_high(seen_high),
    .hold_busy(hold_busy), .delay_met(delay_met)
  );

  assign cpu_ack_n   = ~(grant_q & ~cpu_as_n);
  assign legacy_as_n = cpu_as_n | rom_now;
endmodule

// File: rtl/ack_guard_chk.sv
module ack_guard_chk
  import ack_guard_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    cpu_as_n,
  input logic    cpu_ack_n,
  input logic    legacy_as_n,
  input logic    cycle_start,
  input logic    seen_high,
  input logic    hold_busy,
  input logic    delay_met,
  input region_e region_q
);
  assert_stale_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> cpu_ack_n);

  assert_high_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_ack_n) |-> $past(seen_high));

  assert_rom_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_as_n && !cycle_start && region_q == RGN_ROM) |-> legacy_as_n);

  assert_io_holdoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_ack_n) |-> $past(!hold_busy));

  assert_ram_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cpu_ack_n) && region_q == RGN_RAM) |-> $past(delay_met));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_as_n) |-> cpu_ack_n);

  assert_class_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_as_n && !cycle_start) |=> $stable(region_q));
endmodule

bind ack_guard ack_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n), .cpu_ack_n(cpu_ack_n),
  .legacy_as_n(legacy_as_n), .cycle_start(cycle_start),
  .seen_high(seen_high), .hold_busy(hold_busy),
  .delay_met(delay_met), .region_q(region_q)
);

// File: tb/tb_ack_guard.sv
module tb_ack_guard;
  localparam int AW = 24;
  localparam int RAM_DLY = 2;
  localparam int HOLD = 3;
  localparam logic [AW-1:0] A_ROM = 24'hE00010;
  localparam logic [AW-1:0] A_RAM = 24'h001000;
  localparam logic [AW-1:0] A_IO  = 24'hFF8800;

  logic clk = 1'b0, rst_n = 1'b0, cpu_as_n = 1'b1, ref_clk = 1'b0;
  logic legacy_ack_n = 1'b1;
  logic [AW-1:0] cpu_addr = '0;
  logic cpu_ack_n, legacy_as_n;
  int checks = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always #80 ref_clk = ~ref_clk;
  always @(posedge clk) cyc <= cyc + 1;

  ack_guard #(
    .ADDR_W(AW), .RAM_DELAY(RAM_DLY), .HOLD_EDGES(HOLD),
    .ROM_LO(24'hE00000), .ROM_HI(24'hEFFFFF),
    .RAM_LO(24'h000000), .RAM_HI(24'h3FFFFF)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n), .cpu_addr(cpu_addr),
    .ref_clk(ref_clk), .legacy_ack_n(legacy_ack_n),
    .cpu_ack_n(cpu_ack_n), .legacy_as_n(legacy_as_n)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic release_cycle(input string tag);
    cpu_as_n = 1'b1;
    #1;
    chk(cpu_ack_n == 1'b1, {tag, " R7 ack released with strobe"}, cpu_ack_n, 1);
    tick(1);
  endtask

  task automatic t_reset;
    chk(cpu_ack_n == 1'b1, "R9 ack high in reset", cpu_ack_n, 1);
    chk(legacy_as_n == 1'b1, "R9 legacy strobe high in reset", legacy_as_n, 1);
  endtask

  task automatic t_rom_stale;
    legacy_ack_n = 1'b0;
    tick(4);
    cpu_addr = A_ROM; cpu_as_n = 1'b0;
    tick(1);
    chk(legacy_as_n == 1'b1, "R3 rom isolates legacy strobe", legacy_as_n, 1);
    tick(6);
    chk(cpu_ack_n == 1'b1, "R1 stale low ignored", cpu_ack_n, 1);
    legacy_ack_n = 1'b1;
    tick(3);
    chk(cpu_ack_n == 1'b1, "R1 no ack while legacy high", cpu_ack_n, 1);
    legacy_ack_n = 1'b0;
    tick(2);
    chk(cpu_ack_n == 1'b1, "R2 rom ack not early", cpu_ack_n, 1);
    tick(1);
    chk(cpu_ack_n == 1'b0, "R2 rom ack after 3 edges", cpu_ack_n, 0);
    chk(legacy_as_n == 1'b1, "R3 rom strobe still isolated", legacy_as_n, 1);
    release_cycle("rom");
    legacy_ack_n = 1'b1;
    tick(3);
  endtask

  task automatic t_ram_delay;
    legacy_ack_n = 1'b1;
    cpu_addr = A_RAM; cpu_as_n = 1'b0;
    tick(1);
    chk(legacy_as_n == 1'b0, "R4 ram strobe passes", legacy_as_n, 0);
    tick(1);
    legacy_ack_n = 1'b0;
    tick(2 + RAM_DLY);
    chk(cpu_ack_n == 1'b1, "R6 ram ack held back", cpu_ack_n, 1);
    tick(1);
    chk(cpu_ack_n == 1'b0, "R6 ram ack after delay", cpu_ack_n, 0);
    release_cycle("ram");
    legacy_ack_n = 1'b1;
    tick(3);
  endtask

  task automatic t_addr_latch;
    legacy_ack_n = 1'b1;
    cpu_addr = A_RAM; cpu_as_n = 1'b0;
    tick(1);
    cpu_addr = A_ROM;
    tick(1);
    chk(legacy_as_n == 1'b0, "R8 class held: strobe still passes", legacy_as_n, 0);
    legacy_ack_n = 1'b0;
    tick(3);
    chk(cpu_ack_n == 1'b1, "R8 class held: ram timing kept", cpu_ack_n, 1);
    tick(RAM_DLY);
    chk(cpu_ack_n == 1'b0, "R8 class held: ram ack arrives", cpu_ack_n, 0);
    release_cycle("latch");
    legacy_ack_n = 1'b1;
    tick(3);
  endtask

  task automatic t_io_holdoff;
    int first, gap;
    bit got;
    tick(40);
    legacy_ack_n = 1'b1;
    cpu_addr = A_IO; cpu_as_n = 1'b0;
    tick(1);
    chk(legacy_as_n == 1'b0, "R4 io strobe passes", legacy_as_n, 0);
    tick(1);
    legacy_ack_n = 1'b0;
    tick(3);
    chk(cpu_ack_n == 1'b0, "R2 io ack after 3 edges", cpu_ack_n, 0);
    first = cyc;
    release_cycle("io");
    legacy_ack_n = 1'b1;
    cpu_as_n = 1'b0;
    tick(2);
    legacy_ack_n = 1'b0;
    got = 0;
    gap = 0;
    for (int i = 0; i < 60 && !got; i++) begin
      tick(1);
      if (cpu_ack_n == 1'b0) begin
        got = 1;
        gap = cyc - first;
      end
    end
    chk(got, "R5 io ack eventually returns", got, 1);
    chk(gap >= 16 && gap <= 32, "R5 io holdoff span", gap, 24);
    release_cycle("io2");
    legacy_ack_n = 1'b1;
    tick(3);
  endtask

  initial begin
    tick(2);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_rom_stale();
    t_ram_delay();
    t_addr_latch();
    t_io_holdoff();
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule